// File: doc/BRIEF.md
# Sequential Booth-Recoded Signed Multiplier

This block multiplies two signed two's complement operands of `WIDTH` bits and returns the full signed product of `2*WIDTH` bits. It works one multiplier bit per clock. Each step looks at the current low multiplier bit and the bit that left the register on the step before. From that pair it adds the multiplicand, subtracts it, or leaves the partial sum alone. The combined accumulator/multiplier register then shifts right arithmetically by one place.

A run of ones in the multiplier therefore costs one subtraction where the run begins and one addition just above where it ends, with plain shifts in between. Negative multipliers and negative multiplicands need no sign fix-up at the end. The caller drives both operands with a one-cycle `start_i`, waits for the one-cycle `done_o` pulse, and reads `product_o`. The product then stays put until the next accepted start.

The add/subtract stage is one bit wider than the operands, so the sign of the partial sum survives even for the most negative operand. A parameter chooses between a bit-level ripple adder built by a generate loop and a plain behavioural adder.

Top module: `booth_mult`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0 and `product_o` is all zeros.
- R2: A `start_i` seen high at a rising edge while the unit is idle starts a run. `done_o` goes high after exactly `WIDTH` further rising edges and stays high for exactly one cycle.
- R3: When `done_o` is high, `product_o` equals the signed product of `mcand_i` and `mplier_i` as captured at the accepted start. The product is written as a `2*WIDTH`-bit two's complement value, for operands of either sign (for example 2 × 6 = 12 and 7 × −3 = −21).
- R4: Recoding of the pair (current multiplier bit, previous bit) is as follows, where the previous bit of the first step is 0:
  - (1,0) subtracts the multiplicand.
  - (0,1) adds it.
  - (0,0) and (1,1) only shift.

  As a consequence, a multiplier of −1 yields the negated multiplicand, and alternating bit patterns give correct products.
- R5: Extreme operands give exact results: most-negative × most-negative = 2^(2·WIDTH−2), most-negative × −1 = +2^(WIDTH−1), and most-negative × most-positive is also exact.
- R6: A `start_i` pulse during a run is ignored. The running product and its `done_o` timing are unchanged.
- R7: After `done_o`, `product_o` holds its value unchanged until the next accepted start.
- R8: Operand inputs are sampled only at the accepted start. Changing them during a run does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a multiplication when idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| product_o | output | 2*WIDTH | Signed product, valid from `done_o` until next start |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The start is taken at the edge where `start_i` is high and the unit is idle. The product and `done_o` are due in the cycle after the `WIDTH`-th rising edge that follows that edge. The bench drives inputs on falling edges and counts edges from the start edge. It samples `done_o` low one cycle before that point, samples `done_o` high with the expected product at that point, and samples `done_o` low with an unchanged product one cycle later. Runs that carry a stray start or scrambled operands mid-run use the same timing, so a shifted or extended run shows up as a timing failure as well as a value failure.

// File: rtl/booth_pkg.sv
package booth_pkg;

   typedef enum logic [1:0] {
      STEP_SHIFT = 2'd0,
      STEP_ADD   = 2'd1,
      STEP_SUB   = 2'd2
   } step_e;

   // pair = {current multiplier bit, bit shifted out on previous step}
   function automatic step_e classify(input logic cur, input logic prev);
      step_e s;
      unique case ({cur, prev})
         2'b10:   s = STEP_SUB;
         2'b01:   s = STEP_ADD;
         default: s = STEP_SHIFT;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
   import booth_pkg::*;
(
   input  logic  cur_bit,
   input  logic  prev_bit,
   output step_e step_o,
   output logic  is_sub_o,
   output logic  is_idle_o
);

   always_comb begin
      step_o    = classify(cur_bit, prev_bit);
      is_sub_o  = (step_o == STEP_SUB);
      is_idle_o = (step_o == STEP_SHIFT);
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
   parameter int W      = 17,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o
);

   if (W < 2) begin : g_bad_width
      $error("booth_addsub: W must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0]   carry;
      logic [W-1:0] b_eff;
      assign carry[0] = sub_i;
      assign b_eff    = b_i ^ {W{sub_i}};
      for (genvar k = 0; k < W; k++) begin : g_cell
         assign sum_o[k]   = a_i[k] ^ b_eff[k] ^ carry[k];
         assign carry[k+1] = (a_i[k] & b_eff[k]) | (a_i[k] & carry[k]) |
                             (b_eff[k] & carry[k]);
      end
   end else begin : g_behav
      always_comb begin
         if (sub_i) sum_o = a_i - b_i;
         else       sum_o = a_i + b_i;
      end
   end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
   parameter int STEPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_en_o,
   output logic done_o
);

   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   if (STEPS < 2) begin : g_bad_steps
      $error("booth_ctrl: STEPS must be at least 2");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   assign load_o    = start_i & ~busy_q;
   assign step_en_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // checker-side latency counter, independent of cnt_q
   logic [CW:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= '0;
      else if (load_o) lat_q <= '0;
      else if (busy_q) lat_q <= lat_q + 1'b1;
   end

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == (CW+1)'(STEPS)));

   a_r6_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && cnt_q != LAST) |=> busy_q);

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [WIDTH-1:0]     mcand_i,
   input  logic [WIDTH-1:0]     mplier_i,
   output logic [2*WIDTH-1:0]   product_o,
   output logic                 done_o
);
   import booth_pkg::*;

   localparam int AW = WIDTH + 1;   // guard bit keeps partial-sum sign

   if (WIDTH < 2) begin : g_bad_width
      $error("booth_mult: WIDTH must be at least 2");
   end

   logic             load, step_en;
   logic [AW-1:0]    acc_q, mcand_q, sum, upd;
   logic [WIDTH-1:0] mq_q;
   logic             prev_q;
   step_e            step;
   logic             is_sub, is_idle;

   booth_ctrl #(.STEPS(WIDTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .load_o    (load),
      .step_en_o (step_en),
      .done_o    (done_o)
   );

   booth_recoder u_rec (
      .cur_bit   (mq_q[0]),
      .prev_bit  (prev_q),
      .step_o    (step),
      .is_sub_o  (is_sub),
      .is_idle_o (is_idle)
   );

   booth_addsub #(.W(AW), .RIPPLE(RIPPLE)) u_as (
      .a_i   (acc_q),
      .b_i   (mcand_q),
      .sub_i (is_sub),
      .sum_o (sum)
   );

   assign upd = is_idle ? acc_q : sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mq_q    <= '0;
         prev_q  <= 1'b0;
         mcand_q <= '0;
      end else if (load) begin
         acc_q   <= '0;
         mq_q    <= mplier_i;
         prev_q  <= 1'b0;
         mcand_q <= {mcand_i[WIDTH-1], mcand_i};
      end else if (step_en) begin
         acc_q  <= {upd[AW-1], upd[AW-1:1]};
         mq_q   <= {upd[0], mq_q[WIDTH-1:1]};
         prev_q <= mq_q[0];
      end
   end

   assign product_o = {acc_q[WIDTH-1:0], mq_q};

   a_r7_product_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !start_i) |=> $stable(product_o));

   a_r3_zero_mcand: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && mcand_q == '0) |-> (product_o == '0));

   a_r5_guard_sign: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (acc_q[AW-1] == acc_q[AW-2]));

endmodule

// File: tb/booth_mult_tb.sv
module booth_mult_tb;
   localparam int W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [W-1:0]     mcand_i = '0, mplier_i = '0;
   logic [2*W-1:0]   product_o;
   logic             done_o;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   booth_mult #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .mcand_i(mcand_i), .mplier_i(mplier_i),
      .product_o(product_o), .done_o(done_o)
   );

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      longint sa, sb;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return (2*W)'(sa * sb);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // mode 0 plain, 1 stray start mid-run, 2 scrambled operands mid-run
   task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string req, input int mode);
      logic [2*W-1:0] exp, held;
      exp = ref_mul(a, b);
      @(negedge clk);
      mcand_i = a; mplier_i = b; start_i = 1'b1;
      @(posedge clk);                       // start edge
      for (int i = 1; i < W; i++) begin
         @(negedge clk);
         start_i = (mode == 1 && (i == 3 || i == W-1)) ? 1'b1 : 1'b0;
         if (mode >= 1) begin
            mcand_i = W'($urandom); mplier_i = W'($urandom);
         end
         @(posedge clk);
      end
      @(negedge clk);
      start_i = 1'b0;
      check(done_o == 1'b0, {req, " early done"}, 64'(done_o), 64'd0);
      @(posedge clk);                       // edge W after start
      @(negedge clk);
      check(done_o == 1'b1, {req, " done"}, 64'(done_o), 64'd1);
      check(product_o == exp, {req, " product"}, 64'(product_o), 64'(exp));
      held = product_o;
      @(posedge clk);
      @(negedge clk);
      check(done_o == 1'b0, "R2 done one cycle", 64'(done_o), 64'd0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(product_o == held, "R7 product held", 64'(product_o), 64'(held));
   endtask

   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

   initial begin
      void'($urandom(32'h5EED1));
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R1 reset done", 64'(done_o), 64'd0);
      check(product_o == '0, "R1 reset product", 64'(product_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done_o == 1'b0 && product_o == '0, "R1 after release",
            64'(product_o), 64'd0);

      run(W'(2), W'(6), "R3 2x6", 0);
      run(W'(7), -W'(3), "R3 7x-3", 0);
      run(-W'(9), -W'(11), "R3 neg x neg", 0);
      run(W'(1234), '1, "R4 mult -1", 0);
      run(W'(37), {(W/2){2'b01}}, "R4 alternating 01", 0);
      run(-W'(5), {(W/2){2'b10}}, "R4 alternating 10", 0);
      run(W'(0), W'(77), "R3 zero mcand", 0);
      run(MINV, MINV, "R5 min x min", 0);
      run(MINV, '1, "R5 min x -1", 0);
      run(MINV, MAXV, "R5 min x max", 0);
      run(MAXV, MAXV, "R5 max x max", 0);
      run(W'(300), -W'(41), "R6 stray start", 1);
      run(-W'(1000), W'(999), "R8 scrambled inputs", 2);
      for (int n = 0; n < 150; n++) begin
         run(W'($urandom), W'($urandom), "R3 random", n % 3);
      end
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule